// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit integer core and a memory organised in 32-bit words. It has two paths that share no state. The store path takes a byte address, a width code and the source register value. It produces a per-byte write strobe and the write data, with the data moved into the byte lanes the strobe selects. The load path takes a byte address, a width and sign code and the word read back from memory. It picks out the addressed byte or halfword and widens it to 32 bits, filling the upper bits with zeros or with copies of the sign bit.

Both paths are purely combinational. Only the low two address bits choose lanes, and accesses that would cross a word boundary are not handled. A parameter selects how the store path fills the lanes that are not written. In one variant it copies the byte or halfword into every lane. In the other it drives those lanes to zero.

Top module: `lane_align_unit`

## Requirements
- R1: The width code on `st_kind`/`ld_kind` decodes as 000 = signed byte, 001 = signed halfword, 010 = word, 100 = unsigned byte, 101 = unsigned halfword. Every other code on the load path returns 0. On the store path only 000, 001 and 010 are valid, and any other code gives strobe 0000 and data 0.
- R2: When `st_valid` is 0, `st_strobe` is 0000 and `st_wdata` is 0, whatever the other store inputs are.
- R3: A byte store sets only strobe bit number `st_addr[1:0]`, and source bits [7:0] appear in lane `st_addr[1:0]` (bits 8*k+7 down to 8*k).
- R4: A halfword store sets strobe 0011 when `st_addr[1]` is 0 and 1100 when it is 1, with source bits [15:0] in the selected lane pair. `st_addr[0]` has no effect.
- R5: A word store sets strobe 1111 and passes the source value through unchanged. `st_addr[1:0]` has no effect.
- R6: With `FILL_REPLICATE`=1, a valid byte store drives the source byte into all four lanes and a valid halfword store drives the source halfword into both lane pairs. With `FILL_REPLICATE`=0, every lane outside the strobe is driven to zero.
- R7: A byte load returns lane `ld_addr[1:0]` of `ld_word`. For code 000 the upper 24 bits repeat bit 7 of that byte, and for code 100 they are zero.
- R8: A halfword load returns bits [31:16] of `ld_word` when `ld_addr[1]` is 1 and bits [15:0] when it is 0. Code 001 sign-extends and code 101 zero-extends. `ld_addr[0]` has no effect.
- R9: A word load returns `ld_word` unchanged for every value of `ld_addr[1:0]`.
- R10: Address bits above bit 1 have no effect on any output of either path.
- R11: The store path and the load path run independently, so an active store and an active load given in the same cycle each produce the result they would produce alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_valid | input | 1 | Store request active |
| st_addr | input | AW | Store byte address |
| st_kind | input | 3 | Store width code |
| st_src | input | XLEN | Store source register value |
| st_strobe | output | XLEN/8 | Per-byte write strobe |
| st_wdata | output | XLEN | Lane-aligned write data |
| ld_addr | input | AW | Load byte address |
| ld_kind | input | 3 | Load width and sign code |
| ld_word | input | XLEN | Word read from memory |
| ld_value | output | XLEN | Extended load result |

## Verification
A store and a load can be presented in the same cycle, and because they use separate ports a fault that couples them would only show up then. The bench drives both paths together with different width codes, offsets and patterns whose top bits are set. Some combinations pair a store offset with a different load offset, and others pair a valid code on one path with an invalid code on the other. Each output is compared in that cycle against its own reference model, computed from the requirements alone, so any leakage from one path into the other shows up as a mismatch.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_NONE = 2'd3
   } acc_size_e;

   typedef struct packed {
      acc_size_e size;
      logic      zero_ext;
   } acc_kind_t;

   localparam logic [2:0] KIND_B  = 3'b000;
   localparam logic [2:0] KIND_H  = 3'b001;
   localparam logic [2:0] KIND_W  = 3'b010;
   localparam logic [2:0] KIND_BU = 3'b100;
   localparam logic [2:0] KIND_HU = 3'b101;

endpackage

// File: rtl/lane_kind_decode.sv
module lane_kind_decode
   import lane_align_pkg::*;
#(
   parameter bit STORE_SIDE = 1'b0
) (
   input  logic [2:0] code,
   output acc_kind_t  kind
);

   acc_kind_t unsigned_byte;
   acc_kind_t unsigned_half;

   generate
      if (STORE_SIDE) begin : g_store_codes
         assign unsigned_byte = '{size: SZ_NONE, zero_ext: 1'b0};
         assign unsigned_half = '{size: SZ_NONE, zero_ext: 1'b0};
      end else begin : g_load_codes
         assign unsigned_byte = '{size: SZ_BYTE, zero_ext: 1'b1};
         assign unsigned_half = '{size: SZ_HALF, zero_ext: 1'b1};
      end
   endgenerate

   always_comb begin
      case (code)
         KIND_B:  kind = '{size: SZ_BYTE, zero_ext: 1'b0};
         KIND_H:  kind = '{size: SZ_HALF, zero_ext: 1'b0};
         KIND_W:  kind = '{size: SZ_WORD, zero_ext: 1'b0};
         KIND_BU: kind = unsigned_byte;
         KIND_HU: kind = unsigned_half;
         default: kind = '{size: SZ_NONE, zero_ext: 1'b0};
      endcase
   end

   // R1: a code outside the legal set never yields an access size
   always_comb begin
      if (code == 3'b011 || code[2:1] == 2'b11)
         p_illegal_code_none_r1: assert (kind.size == SZ_NONE);
   end

endmodule

// File: rtl/store_lane_gen.sv
module store_lane_gen
   import lane_align_pkg::*;
#(
   parameter int XLEN           = 32,
   parameter bit FILL_REPLICATE = 1'b1
) (
   input  logic                   en,
   input  logic [$clog2(XLEN/8)-1:0] addr_lo,
   input  acc_kind_t              kind,
   input  logic [XLEN-1:0]        src,
   output logic [XLEN/8-1:0]      mask,
   output logic [XLEN-1:0]        data
);

   localparam int NB  = XLEN / 8;
   localparam int OFS = $clog2(NB);

   logic active;
   logic unused_zx;

   assign active    = en && (kind.size != SZ_NONE);
   assign unused_zx = kind.zero_ext;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      logic       sel;
      logic [7:0] pick;

      always_comb begin
         case (kind.size)
            SZ_BYTE: sel = (addr_lo == OFS'(i));
            SZ_HALF: sel = (addr_lo[OFS-1:1] == (OFS-1)'(i / 2));
            SZ_WORD: sel = 1'b1;
            default: sel = 1'b0;
         endcase
      end

      always_comb begin
         case (kind.size)
            SZ_BYTE: pick = src[7:0];
            SZ_HALF: pick = src[8*(i%2) +: 8];
            default: pick = src[8*i +: 8];
         endcase
      end

      assign mask[i] = active && sel;

      if (FILL_REPLICATE) begin : g_replicate
         assign data[8*i +: 8] = active ? pick : 8'h00;
      end else begin : g_zero_fill
         assign data[8*i +: 8] = (active && sel) ? pick : 8'h00;
      end
   end

   // R2: an idle store path writes nothing
   always_comb begin
      if (!en) begin
         p_idle_no_strobe_r2: assert (mask == '0 && data == '0);
      end
   end

   // R3: a byte store enables exactly one lane
   always_comb begin
      if (en && kind.size == SZ_BYTE)
         p_byte_one_lane_r3: assert ($countones(mask) == 1);
   end

   // R4: a halfword store enables exactly one aligned pair
   always_comb begin
      if (en && kind.size == SZ_HALF)
         p_half_two_lanes_r4: assert ($countones(mask) == 2);
   end

   // R5: a word store enables every lane and passes the source through
   always_comb begin
      if (en && kind.size == SZ_WORD)
         p_word_all_lanes_r5: assert (&mask && data == src);
   end

endmodule

// File: rtl/load_lane_extract.sv
module load_lane_extract
   import lane_align_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [$clog2(XLEN/8)-1:0] addr_lo,
   input  acc_kind_t              kind,
   input  logic [XLEN-1:0]        word,
   output logic [XLEN-1:0]        value
);

   localparam int NB  = XLEN / 8;
   localparam int OFS = $clog2(NB);
   localparam int NH  = NB / 2;

   logic [7:0]  lane_b [NB];
   logic [15:0] lane_h [NH];
   logic [7:0]  byte_v;
   logic [15:0] half_v;
   logic        fill_b;
   logic        fill_h;

   for (genvar i = 0; i < NB; i++) begin : g_byte_lane
      assign lane_b[i] = word[8*i +: 8];
   end

   for (genvar j = 0; j < NH; j++) begin : g_half_lane
      assign lane_h[j] = word[16*j +: 16];
   end

   assign byte_v = lane_b[addr_lo];
   assign half_v = lane_h[addr_lo[OFS-1:1]];
   assign fill_b = !kind.zero_ext && byte_v[7];
   assign fill_h = !kind.zero_ext && half_v[15];

   always_comb begin
      case (kind.size)
         SZ_BYTE: value = {{(XLEN-8){fill_b}}, byte_v};
         SZ_HALF: value = {{(XLEN-16){fill_h}}, half_v};
         SZ_WORD: value = word;
         default: value = '0;
      endcase
   end

   // R7 R8: unsigned narrow loads leave the upper bits clear
   always_comb begin
      if (kind.zero_ext && kind.size != SZ_WORD)
         p_unsigned_upper_zero_r8: assert (value[XLEN-1:16] == '0);
   end

   // R9: word load is a pass-through
   always_comb begin
      if (kind.size == SZ_WORD)
         p_word_passthru_r9: assert (value == word);
   end

   // R1: invalid codes produce a zero result
   always_comb begin
      if (kind.size == SZ_NONE)
         p_none_zero_r1: assert (value == '0);
   end

endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
   import lane_align_pkg::*;
#(
   parameter int XLEN           = 32,
   parameter int AW             = 32,
   parameter bit FILL_REPLICATE = 1'b1
) (
   input  logic              st_valid,
   input  logic [AW-1:0]     st_addr,
   input  logic [2:0]        st_kind,
   input  logic [XLEN-1:0]   st_src,
   output logic [XLEN/8-1:0] st_strobe,
   output logic [XLEN-1:0]   st_wdata,
   input  logic [AW-1:0]     ld_addr,
   input  logic [2:0]        ld_kind,
   input  logic [XLEN-1:0]   ld_word,
   output logic [XLEN-1:0]   ld_value
);

   localparam int NB  = XLEN / 8;
   localparam int OFS = $clog2(NB);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("lane_align_unit: XLEN must be 32");
      end
      if (AW <= OFS) begin : g_bad_aw
         $error("lane_align_unit: AW must exceed the lane offset width");
      end
   endgenerate

   acc_kind_t st_dec;
   acc_kind_t ld_dec;
   logic      unused_hi;

   // R10: only the lane offset bits reach the lane logic
   assign unused_hi = ^{st_addr[AW-1:OFS], ld_addr[AW-1:OFS]};

   lane_kind_decode #(.STORE_SIDE(1'b1)) u_st_dec (
      .code (st_kind),
      .kind (st_dec)
   );

   lane_kind_decode #(.STORE_SIDE(1'b0)) u_ld_dec (
      .code (ld_kind),
      .kind (ld_dec)
   );

   store_lane_gen #(
      .XLEN           (XLEN),
      .FILL_REPLICATE (FILL_REPLICATE)
   ) u_store (
      .en      (st_valid),
      .addr_lo (st_addr[OFS-1:0]),
      .kind    (st_dec),
      .src     (st_src),
      .mask    (st_strobe),
      .data    (st_wdata)
   );

   load_lane_extract #(.XLEN(XLEN)) u_load (
      .addr_lo (ld_addr[OFS-1:0]),
      .kind    (ld_dec),
      .word    (ld_word),
      .value   (ld_value)
   );

endmodule

// File: tb/lane_align_unit_test.sv
module lane_align_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_valid = 1'b0;
   logic [31:0] st_addr = '0;
   logic [2:0]  st_kind = '0;
   logic [31:0] st_src = '0;
   logic [31:0] ld_addr = '0;
   logic [2:0]  ld_kind = '0;
   logic [31:0] ld_word = '0;
   logic [3:0]  st_strobe, zf_strobe;
   logic [31:0] st_wdata, zf_wdata, ld_value, zf_value;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lane_align_unit uut (
      .st_valid(st_valid), .st_addr(st_addr), .st_kind(st_kind), .st_src(st_src),
      .st_strobe(st_strobe), .st_wdata(st_wdata),
      .ld_addr(ld_addr), .ld_kind(ld_kind), .ld_word(ld_word), .ld_value(ld_value)
   );

   lane_align_unit #(.FILL_REPLICATE(1'b0)) uut_zf (
      .st_valid(st_valid), .st_addr(st_addr), .st_kind(st_kind), .st_src(st_src),
      .st_strobe(zf_strobe), .st_wdata(zf_wdata),
      .ld_addr(ld_addr), .ld_kind(ld_kind), .ld_word(ld_word), .ld_value(zf_value)
   );

   localparam logic [31:0] PAT [4] = '{32'h80FF_7F81, 32'hF0E1_D2C3, 32'h1234_ABCD, 32'hC07F_8001};
   localparam logic [29:0] HI  [3] = '{30'h0, 30'h3FFF_FFFF, 30'h1555_5555};

   function automatic logic [35:0] ref_store(input logic en, input logic [2:0] k,
                                             input logic [1:0] a, input logic [31:0] s,
                                             input bit rep);
      logic [3:0]  m = 4'b0000;
      logic [31:0] d = 32'h0;
      if (en) begin
         case (k)
            3'b000: begin
               m = 4'b0001 << a;
               d = rep ? {4{s[7:0]}} : ({24'h0, s[7:0]} << (8 * a));
            end
            3'b001: begin
               m = a[1] ? 4'b1100 : 4'b0011;
               d = rep ? {2{s[15:0]}} : (a[1] ? {s[15:0], 16'h0} : {16'h0, s[15:0]});
            end
            3'b010: begin
               m = 4'b1111;
               d = s;
            end
            default: ;
         endcase
      end
      return {m, d};
   endfunction

   function automatic logic [31:0] ref_load(input logic [2:0] k, input logic [1:0] a,
                                            input logic [31:0] w);
      logic [7:0]  b = w[8*a +: 8];
      logic [15:0] h = a[1] ? w[31:16] : w[15:0];
      case (k)
         3'b000:  return {{24{b[7]}}, b};
         3'b100:  return {24'h0, b};
         3'b001:  return {{16{h[15]}}, h};
         3'b101:  return {16'h0, h};
         3'b010:  return w;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string st_tag(input logic [2:0] k);
      case (k)
         3'b000:  return "R3 R6 R10";
         3'b001:  return "R4 R6 R10";
         3'b010:  return "R5 R10";
         default: return "R1";
      endcase
   endfunction

   function automatic string ld_tag(input logic [2:0] k);
      case (k)
         3'b000, 3'b100: return "R7 R10";
         3'b001, 3'b101: return "R8 R10";
         3'b010:         return "R9 R10";
         default:        return "R1";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic t_idle_store();
      for (int k = 0; k < 8; k++) begin
         @(posedge clk);
         st_valid = 1'b0;
         st_kind  = 3'(k);
         st_addr  = {HI[1], 2'(k)};
         st_src   = PAT[1];
         @(negedge clk);
         chk("R2", "idle strobe", {28'h0, st_strobe}, 32'h0);
         chk("R2", "idle wdata", st_wdata, 32'h0);
         chk("R2", "idle wdata zero-fill", zf_wdata, 32'h0);
      end
   endtask

   task automatic t_store_sweep();
      for (int k = 0; k < 8; k++)
         for (int a = 0; a < 4; a++)
            for (int p = 0; p < 4; p++) begin
               logic [35:0] er, ez;
               @(posedge clk);
               st_valid = 1'b1;
               st_kind  = 3'(k);
               st_addr  = {HI[(a + p) % 3], 2'(a)};
               st_src   = PAT[p];
               er = ref_store(1'b1, 3'(k), 2'(a), PAT[p], 1'b1);
               ez = ref_store(1'b1, 3'(k), 2'(a), PAT[p], 1'b0);
               @(negedge clk);
               chk(st_tag(3'(k)), "store strobe", {28'h0, st_strobe}, {28'h0, er[35:32]});
               chk(st_tag(3'(k)), "store wdata replicate", st_wdata, er[31:0]);
               chk(st_tag(3'(k)), "store wdata zero-fill", zf_wdata, ez[31:0]);
               chk(st_tag(3'(k)), "store strobe zero-fill", {28'h0, zf_strobe}, {28'h0, ez[35:32]});
            end
   endtask

   task automatic t_load_sweep();
      for (int k = 0; k < 8; k++)
         for (int a = 0; a < 4; a++)
            for (int p = 0; p < 4; p++) begin
               @(posedge clk);
               st_valid = 1'b0;
               ld_kind  = 3'(k);
               ld_addr  = {HI[(a + 2 * p) % 3], 2'(a)};
               ld_word  = PAT[p];
               @(negedge clk);
               chk(ld_tag(3'(k)), "load value", ld_value, ref_load(3'(k), 2'(a), PAT[p]));
            end
   endtask

   task automatic t_concurrent();
      for (int n = 0; n < 40; n++) begin
         logic [2:0]  sk = 3'(n % 8);
         logic [2:0]  lk = 3'((n * 3 + 1) % 8);
         logic [1:0]  sa = 2'(n);
         logic [1:0]  la = 2'(n + 2);
         logic [31:0] sp = PAT[n % 4];
         logic [31:0] lp = PAT[(n + 1) % 4];
         logic [35:0] er;
         @(posedge clk);
         st_valid = 1'b1;
         st_kind  = sk;
         st_addr  = {HI[n % 3], sa};
         st_src   = sp;
         ld_kind  = lk;
         ld_addr  = {HI[(n + 1) % 3], la};
         ld_word  = lp;
         er = ref_store(1'b1, sk, sa, sp, 1'b1);
         @(negedge clk);
         chk("R11", "concurrent strobe", {28'h0, st_strobe}, {28'h0, er[35:32]});
         chk("R11", "concurrent wdata", st_wdata, er[31:0]);
         chk("R11", "concurrent load", ld_value, ref_load(lk, la, lp));
      end
   endtask

   always @(posedge clk) begin
      if (rst_n) cycles <= cycles + 1;
   end

   initial begin
      wait (cycles >= 20000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", "initial strobe", {28'h0, st_strobe}, 32'h0);
      t_idle_store();
      t_store_sweep();
      t_load_sweep();
      t_concurrent();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule